// File: doc/BRIEF.md
# Six-Sided Disjoint Routing Switch

This block is the programmable crossing point of a routing fabric built from stacked silicon layers. Each instance has six sides: four that reach neighbouring tiles in the same layer (north, east, south, west) and two that reach the tiles directly above and below (up, down). Every side carries `W` tracks. The arrangement is disjoint: a track can only be joined to the track with the same index on the other five sides. Each track therefore needs one switch cell for every pair of sides, which gives 15 cells per track and a flexibility of 5 for every pin.

A real switch cell is a pair of back-to-back tri-state buffers on a shared wire. Here each pin is split into an input, an output value and an output enable, so the buffers become plain logic. A 2-bit code per cell selects off, one direction or the other. A configuration word is captured on a load strobe.

An asynchronous reset clears the configuration. Every driver is then off from the moment reset rises until a configuration is loaded after reset is released. A per-track flag reports configurations in which a side is driven by one cell and is also the source of another. Such a configuration is still applied.

Top module: `stack_switch`

## Requirements
- R1: While `rst` is high, and after release until the first clock edge with `cfg_load` high, every output enable, every output value and every `conflict` bit is 0, whatever the pin inputs and `cfg_bits` are.
- R2: `cfg_bits` is captured at a rising clock edge with `cfg_load` high and takes effect from that edge. Changes to `cfg_bits` without `cfg_load` have no effect on any output.
- R3: Sides are numbered north=0, east=1, south=2, west=3, up=4, down=5. The cells of a track are ordered by side pair (a,b) with a<b, ascending in a and then in b: (0,1)=cell 0, (0,2)=cell 1, and so on up to (4,5)=cell 14. The code of cell k on track t is at `cfg_bits[(t*15+k)*2 +: 2]`.
- R4: Code 01 on cell (a,b) makes side a's input on that track drive side b: side b's output enable is 1 and its output value follows side a's input.
- R5: Code 10 on cell (a,b) drives in the reverse direction, from side b to side a.
- R6: Codes 00 and 11 both leave the cell off: it drives neither side.
- R7: A cell on track t affects only track t on every side. All other tracks are unchanged.
- R8: Each side of each track can be driven from each of the other five sides, which gives 30 directed connections per track.
- R9: When several enabled cells drive the same side, its output value is the OR of their source inputs, and its output enable is 1 if at least one of them is enabled.
- R10: `conflict[t]` is 1 exactly when some side of track t is both driven by an enabled cell and the source of another enabled cell. The outputs still follow the configuration in that case.
- R11: Raising `rst` at any time, with no clock edge, at once forces all output enables and values to 0 and discards the loaded configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration capture |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_load | input | 1 | Capture `cfg_bits` at this clock edge |
| cfg_bits | input | 30*W | Cell codes, track-major, 2 bits per cell |
| north_in | input | W | Track inputs from the north side |
| north_out | output | W | Values driven onto the north side |
| north_oe | output | W | Drive enables for the north side |
| east_in | input | W | Track inputs from the east side |
| east_out | output | W | Values driven onto the east side |
| east_oe | output | W | Drive enables for the east side |
| south_in | input | W | Track inputs from the south side |
| south_out | output | W | Values driven onto the south side |
| south_oe | output | W | Drive enables for the south side |
| west_in | input | W | Track inputs from the west side |
| west_out | output | W | Values driven onto the west side |
| west_oe | output | W | Drive enables for the west side |
| up_in | input | W | Track inputs from the layer above |
| up_out | output | W | Values driven to the layer above |
| up_oe | output | W | Drive enables toward the layer above |
| down_in | input | W | Track inputs from the layer below |
| down_out | output | W | Values driven to the layer below |
| down_oe | output | W | Drive enables toward the layer below |
| conflict | output | W | Per-track flag: a side is both driven and driving |

## Verification
The bench first sweeps single-cell configurations over every track, every side pair and both directions. It drives all-ones and random inputs, which separates swapped directions, misplaced bit fields and crosstalk between tracks. It then tries configurations with several drivers into one side to check the OR merge, with chains and fans to tell a real conflict from a plain fan-out, and with the two off codes. Random configurations, mixed with loads and with changes to `cfg_bits` that are not loaded, check the capture timing. A reset raised between clock edges checks that the drivers turn off at once.

// File: rtl/stack_switch.sv
module stack_switch #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic [30*W-1:0] cfg_bits,
  input  logic [W-1:0]    north_in,
  output logic [W-1:0]    north_out,
  output logic [W-1:0]    north_oe,
  input  logic [W-1:0]    east_in,
  output logic [W-1:0]    east_out,
  output logic [W-1:0]    east_oe,
  input  logic [W-1:0]    south_in,
  output logic [W-1:0]    south_out,
  output logic [W-1:0]    south_oe,
  input  logic [W-1:0]    west_in,
  output logic [W-1:0]    west_out,
  output logic [W-1:0]    west_oe,
  input  logic [W-1:0]    up_in,
  output logic [W-1:0]    up_out,
  output logic [W-1:0]    up_oe,
  input  logic [W-1:0]    down_in,
  output logic [W-1:0]    down_out,
  output logic [W-1:0]    down_oe,
  output logic [W-1:0]    conflict
);
  localparam int SIDES = 6;
  localparam int CELLS = SIDES * (SIDES - 1) / 2;
  localparam int CW    = 2 * CELLS * W;

  logic [CW-1:0]             cfg_q;
  logic [SIDES-1:0][W-1:0]   pin_in, pin_out, pin_oe, feeds;
  logic [1:0]                code;

  assign pin_in = {down_in, up_in, west_in, south_in, east_in, north_in};

  always_ff @(posedge clk or posedge rst)
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_bits;

  always_comb begin
    pin_out  = '0;
    pin_oe   = '0;
    feeds    = '0;
    conflict = '0;
    code     = 2'b00;
    for (int t = 0; t < W; t++) begin
      for (int a = 0; a < SIDES - 1; a++) begin
        for (int b = a + 1; b < SIDES; b++) begin
          code = cfg_q[(t*CELLS + a*(2*SIDES-1-a)/2 + b - a - 1)*2 +: 2];
          if (code == 2'b01) begin
            pin_oe[b][t]  = 1'b1;
            pin_out[b][t] = pin_out[b][t] | pin_in[a][t];
            feeds[a][t]   = 1'b1;
          end else if (code == 2'b10) begin
            pin_oe[a][t]  = 1'b1;
            pin_out[a][t] = pin_out[a][t] | pin_in[b][t];
            feeds[b][t]   = 1'b1;
          end
        end
      end
      for (int s = 0; s < SIDES; s++)
        conflict[t] = conflict[t] | (pin_oe[s][t] & feeds[s][t]);
    end
  end

  assign north_out = pin_out[0];
  assign east_out  = pin_out[1];
  assign south_out = pin_out[2];
  assign west_out  = pin_out[3];
  assign up_out    = pin_out[4];
  assign down_out  = pin_out[5];
  assign north_oe  = pin_oe[0];
  assign east_oe   = pin_oe[1];
  assign south_oe  = pin_oe[2];
  assign west_oe   = pin_oe[3];
  assign up_oe     = pin_oe[4];
  assign down_oe   = pin_oe[5];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (pin_oe == '0)); // R1
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst) !cfg_load |=> ($stable(pin_oe) && $stable(conflict))); // R2
  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (rst) ((pin_out & ~pin_oe) == '0)); // R4
  AST_CONFLICT_HAS_DRIVE: assert property (@(posedge clk) disable iff (rst) (|conflict) |-> ($countones(pin_oe) >= 1)); // R10
endmodule

// File: tb/test_stack_switch.sv
module test_stack_switch;
  localparam int W     = 8;
  localparam int SIDES = 6;
  localparam int CELLS = 15;
  localparam int CW    = 2 * CELLS * W;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0;
  logic [CW-1:0] cfg_bits = '0;
  logic [SIDES-1:0][W-1:0] pin_i = '0;
  logic [SIDES-1:0][W-1:0] pin_o, pin_e;
  logic [W-1:0] confl;
  logic [CW-1:0] mcfg;
  int checks = 0, fails = 0;
  string tag = "R1 reset held";

  always #5 clk = ~clk;

  stack_switch #(.W(W)) i_stack_switch (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bits(cfg_bits),
    .north_in(pin_i[0]), .north_out(pin_o[0]), .north_oe(pin_e[0]),
    .east_in(pin_i[1]),  .east_out(pin_o[1]),  .east_oe(pin_e[1]),
    .south_in(pin_i[2]), .south_out(pin_o[2]), .south_oe(pin_e[2]),
    .west_in(pin_i[3]),  .west_out(pin_o[3]),  .west_oe(pin_e[3]),
    .up_in(pin_i[4]),    .up_out(pin_o[4]),    .up_oe(pin_e[4]),
    .down_in(pin_i[5]),  .down_out(pin_o[5]),  .down_oe(pin_e[5]),
    .conflict(confl)
  );

  always @(posedge clk or posedge rst)
    if (rst) mcfg <= '0;
    else if (cfg_load) mcfg <= cfg_bits;

  function automatic int cell_of(int a, int b);
    int n = 0;
    for (int x = 0; x < SIDES; x++)
      for (int y = x + 1; y < SIDES; y++) begin
        if (x == a && y == b) return n;
        n++;
      end
    return -1;
  endfunction

  task automatic compare();
    logic [SIDES-1:0][W-1:0] eo, ee;
    logic [W-1:0] ec;
    logic [SIDES-1:0] src, drv;
    logic [1:0] c;
    eo = '0; ee = '0; ec = '0;
    for (int t = 0; t < W; t++) begin
      src = '0; drv = '0;
      for (int a = 0; a < SIDES; a++)
        for (int b = a + 1; b < SIDES; b++) begin
          c = mcfg[(t*CELLS + cell_of(a, b))*2 +: 2];
          if (c == 2'd1) begin drv[b] = 1'b1; src[a] = 1'b1; eo[b][t] = eo[b][t] | pin_i[a][t]; end
          if (c == 2'd2) begin drv[a] = 1'b1; src[b] = 1'b1; eo[a][t] = eo[a][t] | pin_i[b][t]; end
        end
      for (int s = 0; s < SIDES; s++) ee[s][t] = drv[s];
      ec[t] = |(drv & src);
    end
    checks++;
    if (pin_o !== eo || pin_e !== ee || confl !== ec) begin
      fails++;
      $display("FAIL %s: out=%h oe=%h conflict=%h expected out=%h oe=%h conflict=%h",
               tag, pin_o, pin_e, confl, eo, ee, ec);
    end
  endtask

  always @(negedge clk) compare();

  function automatic logic [CW-1:0] one_cell(int t, int a, int b, logic [1:0] c);
    logic [CW-1:0] v = '0;
    v[(t*CELLS + cell_of(a, b))*2 +: 2] = c;
    return v;
  endfunction

  function automatic logic [CW-1:0] rand_cfg();
    logic [CW-1:0] v;
    for (int i = 0; i < CW; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  task automatic rand_inputs();
    for (int s = 0; s < SIDES; s++) pin_i[s] = W'($urandom);
  endtask

  task automatic load(input logic [CW-1:0] v);
    @(posedge clk); #1 cfg_bits = v; cfg_load = 1'b1;
    @(posedge clk); #1 cfg_load = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(posedge clk); #1 rand_inputs(); end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    logic [CW-1:0] v;
    tag = "R1 reset held, load ignored";
    cfg_load = 1'b1; cfg_bits = '1;
    run(4);
    @(posedge clk); #1 rst = 1'b0; cfg_load = 1'b0; cfg_bits = rand_cfg();
    tag = "R1 R2 unloaded after release";
    run(4);

    tag = "R3 R4 R5 R7 R8 single cell sweep";
    for (int t = 0; t < W; t++)
      for (int a = 0; a < SIDES; a++)
        for (int b = a + 1; b < SIDES; b++)
          for (int c = 1; c <= 2; c++) begin
            load(one_cell(t, a, b, 2'(c)));
            pin_i = '1;
            run(1);
          end

    tag = "R6 codes 00 and 11 off";
    v = '0;
    for (int i = 0; i < CW / 2; i++) v[i*2 +: 2] = 2'b11;
    load(v); run(4);
    load('0); run(2);

    tag = "R9 merged drivers into up";
    load(one_cell(2, 0, 4, 2'd1) | one_cell(2, 1, 4, 2'd1) | one_cell(2, 4, 5, 2'd2));
    for (int p = 0; p < 8; p++) begin
      @(posedge clk); #1 pin_i = '0;
      pin_i[0][2] = p[0]; pin_i[1][2] = p[1]; pin_i[5][2] = p[2];
    end
    run(4);

    tag = "R10 chain north->east->south";
    load(one_cell(5, 0, 1, 2'd1) | one_cell(5, 1, 2, 2'd1)); run(4);
    tag = "R10 fan-out without conflict";
    load(one_cell(5, 0, 1, 2'd1) | one_cell(5, 0, 2, 2'd1)); run(4);

    tag = "R2 unloaded cfg change";
    load(rand_cfg());
    repeat (6) begin @(posedge clk); #1 cfg_bits = rand_cfg(); rand_inputs(); end

    tag = "R11 async reset";
    load(rand_cfg()); run(2);
    @(posedge clk); #3 rst = 1'b1;
    #1 compare();
    cfg_load = 1'b1; cfg_bits = '1;
    run(2);
    @(posedge clk); #1 rst = 1'b0; cfg_load = 1'b0;
    tag = "R11 R1 config discarded";
    run(3);

    tag = "R2 R7 R9 R10 random";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1
      cfg_load = ($urandom % 4 == 0);
      cfg_bits = rand_cfg() & rand_cfg();
      rand_inputs();
    end
    @(posedge clk); #1 cfg_load = 1'b0;
    run(2);
    finish_up();
  end
endmodule